// File: doc/BRIEF.md
# Infrared Dongle Serial Register Master

This block drives a two-wire serial link to an external infrared transceiver dongle. It reads and writes the dongle's indexed configuration registers. The master owns a clock pin and a data pin. A single input pin returns both the dongle's ready indication and its read data. Every pin level is held for one half-period, which is a whole number of system clocks set by `div_i`.

A host issues one of three commands with a start strobe. The first is a single register transfer, either a write or a read. The second is a dongle reset burst. The third is a mode-setup script. The script chains a reset, three configuration writes and a read-back with no idle gap between them. `busy_o` covers the whole command and `done_o` marks its end. A read returns its byte on `rdata_o`. If the dongle never signals ready, the read raises `nack_o` instead.

Top module: `dongle_ser_master`

## Requirements
- R1: After reset, `dng_clk_o`, `dng_dat_o`, `busy_o`, `done_o`, `nack_o` and `rdata_o` are all zero.
- R2: A transfer starts with one half of clock low and data low, then one half of clock high and data low. The command byte follows, formed as `addr_i | (idx_i << 1) | dir`, where dir is 1 for a write and 0 for a read. Bits go out least significant first. Each bit takes a half with the clock low and data set to the bit, then a half with the clock high and the same data. Data never changes while the new clock level is high.
- R3: A write (`cmd_i`=0, `rw_i`=1) sends the command byte and then `wdata_i` in the same bit format. It then holds clock low and data low for one half, and gives two pulses with data low. Each pulse is a clock-high half followed by a clock-low half. Both pins are low whenever the block is idle.
- R4: A read (`cmd_i`=0, `rw_i`=0) sends the command byte and then holds clock low and data high for one half. It then issues up to 10 poll pulses with data high. At the end of each pulse's low half it samples the synchronized input, and it stops polling at the first low sample.
- R5: Once ready is seen, 8 more pulses with data high clock in the read byte, least significant bit first. Each bit is sampled at the end of its pulse's low half. When the command completes, `rdata_o` holds the byte and `nack_o` is 0.
- R6: If all 10 polls read high, the block issues 2 further pulses with data high. The read then completes with `rdata_o`=0 and `nack_o`=1.
- R7: Every read ends the same way. There is one pulse with data high, then one half with clock low and data low, then 3 pulses with data low.
- R8: The reset command (`cmd_i`=1) gives one half with both pins low, followed by 30 pulses with data low.
- R9: The setup command (`cmd_i`=2) runs five steps back to back, all on device address 0x40: a reset burst; a write of 0x17 to index 0; a write of `wdata_i` to index 1; a write of 0xFF to index 2; a read of index 1. The read result is reported as in R5 and R6.
- R10: Each half lasts `div_i` system clocks, and a `div_i` of 0 behaves as 1. The data input passes through two flip-flops before it is sampled.
- R11: `busy_o` rises in the cycle after an accepted start and stays high until `done_o` pulses for exactly one cycle. A start while busy is ignored, and so is a start with `cmd_i`=3.
- R12: `rdata_o` and `nack_o` change only when a read completes. Reset bursts and writes leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, taken when idle |
| cmd_i | input | 2 | 0 transfer, 1 reset burst, 2 mode setup, 3 none |
| rw_i | input | 1 | Transfer direction: 1 write, 0 read |
| addr_i | input | 8 | Device address, ORed into the command byte |
| idx_i | input | 7 | Register index |
| wdata_i | input | 8 | Write data; the mode value for setup |
| div_i | input | DIV_W | Half-period in system clocks |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last read result |
| nack_o | output | 1 | Last read got no ready indication |
| dng_clk_o | output | 1 | Serial clock to the dongle |
| dng_dat_o | output | 1 | Serial data to the dongle |
| dng_dat_i | input | 1 | Ready and read data from the dongle |

## Verification
The checker enforces the pin-level invariants on every cycle:
- data moves only while the new clock level is low;
- both pins rest low while idle;
- a no-response result always carries a zero byte;
- done is a single-cycle pulse outside busy, and busy only begins after a strobe;
- the read result changes only on completion.

The exact half-period sequence of each transaction cannot be shown by those invariants. This includes the bit order of the command byte, where polling stops, the dummy pulses, the trailer shapes and the five-step setup chaining. The bench's per-cycle waveform model compares all of it. Ready timing at the first and last poll, timeout, different divider values and ignored strobes are covered only by the bench's scenarios.

// File: rtl/dongle_pkg.sv
package dongle_pkg;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned POLL_LIMIT   = 10;
  localparam int unsigned DUMMY_PULSES = 2;
  localparam int unsigned WR_TAIL      = 2;
  localparam int unsigned RD_TAIL      = 3;
  localparam int unsigned RST_PULSES   = 30;
  localparam int unsigned CNT_W        = $clog2(RST_PULSES + 1);
  localparam int unsigned STEP_W       = 3;
  localparam logic [STEP_W-1:0] STEP_LAST = 3'd4;
  localparam logic [BYTE_W-1:0] SETUP_ADDR = 8'h40;
  localparam logic [BYTE_W-1:0] SETUP_CFG0 = 8'h17;
  localparam logic [BYTE_W-1:0] SETUP_CFG2 = 8'hFF;

  typedef enum logic [1:0] {CMD_XFER = 2'd0, CMD_RESET = 2'd1, CMD_SETUP = 2'd2, CMD_NONE = 2'd3} cmd_e;
  typedef enum logic [1:0] {OP_WR, OP_RD, OP_RST} op_e;
  typedef enum logic [3:0] {
    PH_IDLE, PH_LEAD0, PH_LEAD1, PH_BIT, PH_LOW, PH_TAIL,
    PH_RGAP, PH_POLL, PH_DATA, PH_DUMMY, PH_RT1
  } ph_e;
endpackage

// File: rtl/dongle_sync.sv
module dongle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;  // idle line level
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end
  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/dongle_timer.sv
module dongle_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             last_o
);
  logic [DIV_W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (restart_i)      cnt_q <= (div_i == '0) ? '0 : div_i - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end
  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/dongle_step_sel.sv
module dongle_step_sel
  import dongle_pkg::*;
(
  input  cmd_e                cmd_i,
  input  logic [STEP_W-1:0]   step_i,
  input  logic                rw_i,
  input  logic [BYTE_W-1:0]   addr_i,
  input  logic [BYTE_W-2:0]   idx_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output op_e                 op_o,
  output logic [BYTE_W-1:0]   cmd_byte_o,
  output logic [BYTE_W-1:0]   data_o
);
  logic [BYTE_W-1:0] addr;
  logic [BYTE_W-2:0] idx;
  always_comb begin
    addr   = addr_i;
    idx    = idx_i;
    data_o = wdata_i;
    op_o   = rw_i ? OP_WR : OP_RD;
    if (cmd_i == CMD_RESET) begin
      op_o = OP_RST;
    end else if (cmd_i == CMD_SETUP) begin
      addr = SETUP_ADDR;
      case (step_i)
        3'd0:    op_o = OP_RST;
        3'd1:    begin op_o = OP_WR; idx = '0;             data_o = SETUP_CFG0; end
        3'd2:    begin op_o = OP_WR; idx = (BYTE_W-1)'(1); end
        3'd3:    begin op_o = OP_WR; idx = (BYTE_W-1)'(2); data_o = SETUP_CFG2; end
        default: begin op_o = OP_RD; idx = (BYTE_W-1)'(1); end
      endcase
    end
    cmd_byte_o = addr | {idx, 1'b0} | {{(BYTE_W-1){1'b0}}, op_o == OP_WR};
  end
endmodule

// File: rtl/dongle_ser_master.sv
module dongle_ser_master
  import dongle_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        cmd_i,
  input  logic              rw_i,
  input  logic [7:0]        addr_i,
  input  logic [6:0]        idx_i,
  input  logic [7:0]        wdata_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        rdata_o,
  output logic              nack_o,
  output logic              dng_clk_o,
  output logic              dng_dat_o,
  input  logic              dng_dat_i
);
  localparam int unsigned SH_W = 2 * BYTE_W;

  ph_e                ph_q, ph_d;
  op_e                op_q, op_d;
  logic               hs_q, hs_d, ok_q, ok_d, done_d, nack_d;
  logic [CNT_W-1:0]   n_q, n_d, tn_q, tn_d;
  logic [SH_W-1:0]    sh_q, sh_d;
  logic [BYTE_W-1:0]  rx_q, rx_d, rdata_d;
  logic [STEP_W-1:0]  step_q, step_d;
  cmd_e               cmd_q;
  logic               rw_q;
  logic [7:0]         addr_q, wd_q;
  logic [6:0]         idx_q;
  logic               busy, half_end, rx_s, begin_op, end_op, more;
  op_e                sel_op;
  logic [BYTE_W-1:0]  sel_cmd, sel_data;
  logic [1:0]         pins_d;

  assign busy = (ph_q != PH_IDLE);
  assign more = (cmd_q == CMD_SETUP) && (step_q != STEP_LAST);

  dongle_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(dng_dat_i), .q_o(rx_s));

  dongle_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(begin_op | (busy & half_end)),
    .div_i(div_i), .last_o(half_end));

  // idle: look at the live request; busy: look at the next setup step
  dongle_step_sel u_sel (
    .cmd_i     (busy ? cmd_q : cmd_e'(cmd_i)),
    .step_i    (busy ? step_q + 3'd1 : '0),
    .rw_i      (busy ? rw_q : rw_i),
    .addr_i    (busy ? addr_q : addr_i),
    .idx_i     (busy ? idx_q : idx_i),
    .wdata_i   (busy ? wd_q : wdata_i),
    .op_o      (sel_op),
    .cmd_byte_o(sel_cmd),
    .data_o    (sel_data));

  function automatic logic [1:0] pins(ph_e p, logic h, logic b);  // {clk, dat}
    case (p)
      PH_LEAD1:                            return 2'b10;
      PH_BIT:                              return {h, b};
      PH_TAIL:                             return {~h, 1'b0};
      PH_RGAP:                             return 2'b01;
      PH_POLL, PH_DATA, PH_DUMMY, PH_RT1:  return {~h, 1'b1};
      default:                             return 2'b00;
    endcase
  endfunction

  always_comb begin
    ph_d = ph_q; op_d = op_q; hs_d = hs_q; n_d = n_q; tn_d = tn_q; sh_d = sh_q;
    rx_d = rx_q; ok_d = ok_q; step_d = step_q; rdata_d = rdata_o; nack_d = nack_o;
    done_d = 1'b0; begin_op = 1'b0; end_op = 1'b0;
    if (!busy) begin
      if (start_i && cmd_e'(cmd_i) != CMD_NONE) begin
        begin_op = 1'b1;
        step_d   = '0;
      end
    end else if (half_end) begin
      case (ph_q)
        PH_LEAD0: ph_d = PH_LEAD1;
        PH_LEAD1: begin
          ph_d = PH_BIT; hs_d = 1'b0;
          n_d  = (op_q == OP_WR) ? CNT_W'(SH_W - 1) : CNT_W'(BYTE_W - 1);
        end
        PH_BIT: begin
          hs_d = ~hs_q;
          if (hs_q) begin
            if (n_q != '0) begin
              n_d = n_q - 1'b1; sh_d = sh_q >> 1;
            end else if (op_q == OP_WR) begin
              ph_d = PH_LOW; tn_d = CNT_W'(WR_TAIL);
            end else begin
              ph_d = PH_RGAP;
            end
          end
        end
        PH_LOW: begin ph_d = PH_TAIL; hs_d = 1'b0; n_d = tn_q - 1'b1; end
        PH_TAIL: begin
          hs_d = ~hs_q;
          if (hs_q) begin
            if (n_q == '0) end_op = 1'b1;
            else           n_d = n_q - 1'b1;
          end
        end
        PH_RGAP: begin ph_d = PH_POLL; hs_d = 1'b0; n_d = CNT_W'(POLL_LIMIT - 1); end
        PH_POLL: begin
          hs_d = ~hs_q;
          if (hs_q) begin
            if (!rx_s) begin
              ph_d = PH_DATA; ok_d = 1'b1; n_d = CNT_W'(BYTE_W - 1);
            end else if (n_q == '0) begin
              ph_d = PH_DUMMY; n_d = CNT_W'(DUMMY_PULSES - 1);
            end else begin
              n_d = n_q - 1'b1;
            end
          end
        end
        PH_DATA, PH_DUMMY: begin
          hs_d = ~hs_q;
          if (hs_q) begin
            if (ph_q == PH_DATA) rx_d = {rx_s, rx_q[BYTE_W-1:1]};
            if (n_q == '0) ph_d = PH_RT1;
            else           n_d = n_q - 1'b1;
          end
        end
        PH_RT1: begin
          hs_d = ~hs_q;
          if (hs_q) begin ph_d = PH_LOW; tn_d = CNT_W'(RD_TAIL); end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
    if (end_op) begin
      if (op_q == OP_RD) begin
        rdata_d = ok_q ? rx_q : '0;
        nack_d  = ~ok_q;
      end
      if (more) begin
        begin_op = 1'b1;
        step_d   = step_q + 3'd1;
      end else begin
        ph_d = PH_IDLE; hs_d = 1'b0; done_d = 1'b1;
      end
    end
    if (begin_op) begin
      op_d = sel_op; hs_d = 1'b0; rx_d = '0; ok_d = 1'b0;
      sh_d = {sel_data, sel_cmd};
      if (sel_op == OP_RST) begin ph_d = PH_LOW; tn_d = CNT_W'(RST_PULSES); end
      else                        ph_d = PH_LEAD0;
    end
    pins_d = pins(ph_d, hs_d, sh_d[0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE; op_q <= OP_RST; hs_q <= 1'b0; ok_q <= 1'b0;
      n_q <= '0; tn_q <= '0; sh_q <= '0; rx_q <= '0; step_q <= '0;
      rdata_o <= '0; nack_o <= 1'b0; done_o <= 1'b0;
      dng_clk_o <= 1'b0; dng_dat_o <= 1'b0;
      cmd_q <= CMD_NONE; rw_q <= 1'b0; addr_q <= '0; idx_q <= '0; wd_q <= '0;
    end else begin
      ph_q <= ph_d; op_q <= op_d; hs_q <= hs_d; ok_q <= ok_d;
      n_q <= n_d; tn_q <= tn_d; sh_q <= sh_d; rx_q <= rx_d; step_q <= step_d;
      rdata_o <= rdata_d; nack_o <= nack_d; done_o <= done_d;
      {dng_clk_o, dng_dat_o} <= pins_d;
      if (!busy && begin_op) begin
        cmd_q <= cmd_e'(cmd_i); rw_q <= rw_i; addr_q <= addr_i; idx_q <= idx_i; wd_q <= wdata_i;
      end
    end
  end

  assign busy_o = busy;
endmodule

// File: rtl/dongle_ser_master_chk.sv
module dongle_ser_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       nack_o,
  input logic [7:0] rdata_o,
  input logic       dng_clk_o,
  input logic       dng_dat_o
);
  assert_data_clk_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dng_dat_o) |-> !dng_clk_o);
  assert_idle_pins_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!dng_clk_o && !dng_dat_o));
  assert_nack_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |-> (rdata_o == 8'h00));
  assert_done_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_not_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_busy_after_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  assert_result_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(rdata_o) && $stable(nack_o)));
endmodule

bind dongle_ser_master dongle_ser_master_chk u_chk (.*);

// File: tb/sim_dongle_ser_master.sv
`timescale 1ns/1ps
module sim_dongle_ser_master;
  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, rw_i = 1'b0, dat_i = 1'b1;
  logic [1:0] cmd_i = 2'd0;
  logic [7:0] addr_i = '0, wdata_i = '0, div_i = 8'd2, rdata_o;
  logic [6:0] idx_i = '0;
  logic busy_o, done_o, nack_o, dclk, ddat;

  always #2 clk = ~clk;

  dongle_ser_master u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cmd_i(cmd_i), .rw_i(rw_i),
    .addr_i(addr_i), .idx_i(idx_i), .wdata_i(wdata_i), .div_i(div_i),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .nack_o(nack_o),
    .dng_clk_o(dclk), .dng_dat_o(ddat), .dng_dat_i(dat_i));

  int checks = 0, fails = 0, hp = 2, len = 0, cycles = 0;
  bit ec [0:4095];
  bit ed [0:4095];
  bit di [0:4095];
  logic [7:0] exp_rd = '0;
  logic exp_nack = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, expv);
    end
  endtask

  task automatic add_half(input bit c, input bit d, input bit in);
    for (int k = 0; k < hp; k++) begin
      ec[len] = c; ed[len] = d; di[len] = in; len++;
    end
  endtask

  task automatic add_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin add_half(0, b[i], 1); add_half(1, b[i], 1); end
  endtask

  task automatic add_pulses(input int n, input bit d);
    for (int i = 0; i < n; i++) begin add_half(1, d, 1); add_half(0, d, 1); end
  endtask

  task automatic m_wr(input logic [7:0] a, input logic [6:0] ix, input logic [7:0] d);
    add_half(0, 0, 1); add_half(1, 0, 1);
    add_byte(a | {ix, 1'b0} | 8'h01);
    add_byte(d);
    add_half(0, 0, 1); add_pulses(2, 0);
  endtask

  // k: polls that read high before ready; k >= 10 means no response
  task automatic m_rd(input logic [7:0] a, input logic [6:0] ix, input int k, input logic [7:0] v);
    add_half(0, 0, 1); add_half(1, 0, 1);
    add_byte(a | {ix, 1'b0});
    add_half(0, 1, 1);
    for (int j = 0; j < 10; j++) begin
      bit hi = (j < k);
      add_half(1, 1, hi); add_half(0, 1, hi);
      if (!hi) break;
    end
    if (k < 10) begin
      for (int i = 0; i < 8; i++) begin add_half(1, 1, v[i]); add_half(0, 1, v[i]); end
      exp_rd = v; exp_nack = 1'b0;
    end else begin
      add_pulses(2, 1);
      exp_rd = 8'h00; exp_nack = 1'b1;
    end
    add_pulses(1, 1); add_half(0, 0, 1); add_pulses(3, 0);
  endtask

  task automatic m_rst();
    add_half(0, 0, 1); add_pulses(30, 0);
  endtask

  task automatic run(input logic [1:0] cmd, input logic rw, input logic [7:0] a,
                     input logic [6:0] ix, input logic [7:0] wd, input string req, input int poke);
    @(negedge clk);
    cmd_i = cmd; rw_i = rw; addr_i = a; idx_i = ix; wdata_i = wd; start_i = 1'b1;
    dat_i = (len > 1) ? di[1] : 1'b1;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      start_i = (c == poke);
      if (c == poke) cmd_i = 2'd1;
      check(dclk == ec[c] && ddat == ed[c] && busy_o && !done_o, req,
            {dclk, ddat, busy_o, done_o}, {ec[c], ed[c], 2'b10});
      dat_i = (c + 2 < len) ? di[c + 2] : 1'b1;
    end
    @(negedge clk);
    start_i = 1'b0;
    check(done_o && !busy_o && !dclk && !ddat, "R11 done", {dclk, ddat, busy_o, done_o}, 4'b0001);
    check(rdata_o == exp_rd && nack_o == exp_nack, {req, " R12 result"},
          {nack_o, rdata_o}, {exp_nack, exp_rd});
    @(negedge clk);
    check(!done_o && !busy_o, "R11 single done", {busy_o, done_o}, 0);
    len = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!dclk && !ddat && !busy_o && !done_o && !nack_o && rdata_o == 0, "R1",
          {dclk, ddat, busy_o, done_o, nack_o, rdata_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!dclk && !ddat && !busy_o && !done_o, "R1 after release", {dclk, ddat, busy_o, done_o}, 0);

    // R2 R3: write, half period 2
    hp = 2; div_i = 8'd2;
    m_wr(8'h40, 7'd5, 8'hA5); run(2'd0, 1'b1, 8'h40, 7'd5, 8'hA5, "R3 write", -1);
    // R2 R4 R5 R7: overlapping address and index bits, ready after 3 polls, half period 3
    hp = 3; div_i = 8'd3;
    m_rd(8'h03, 7'd1, 3, 8'h6C); run(2'd0, 1'b0, 8'h03, 7'd1, 8'h00, "R5 read", -1);
    // R10: divider 0 behaves as 1; ready on first poll
    hp = 1; div_i = 8'd0;
    m_rd(8'h22, 7'd9, 0, 8'h81); run(2'd0, 1'b0, 8'h22, 7'd9, 8'h00, "R10 read div0", -1);
    // R4: ready at the last allowed poll
    hp = 2; div_i = 8'd2;
    m_rd(8'h10, 7'd3, 9, 8'h3C); run(2'd0, 1'b0, 8'h10, 7'd3, 8'h00, "R4 last poll", -1);
    // R6: no response
    m_rd(8'h10, 7'd4, 10, 8'hFF); run(2'd0, 1'b0, 8'h10, 7'd4, 8'h00, "R6 no response", -1);
    // R12: write leaves nack/rdata from previous read
    m_wr(8'h00, 7'd7, 8'h5A); run(2'd0, 1'b1, 8'h00, 7'd7, 8'h5A, "R12 write keeps result", 20);
    // R8 R11: reset burst with a start strobe mid-way (ignored)
    m_rst(); run(2'd1, 1'b0, 8'h00, 7'd0, 8'h00, "R8 reset", 40);
    // R11: command code 3 ignored
    @(negedge clk);
    cmd_i = 2'd3; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      check(!busy_o && !done_o && !dclk && !ddat, "R11 cmd3 ignored", {busy_o, done_o, dclk, ddat}, 0);
      @(negedge clk);
    end
    // R9: setup script, mode 0x03, read-back ready after 2 polls
    m_rst(); m_wr(8'h40, 7'd0, 8'h17); m_wr(8'h40, 7'd1, 8'h03); m_wr(8'h40, 7'd2, 8'hFF);
    m_rd(8'h40, 7'd1, 2, 8'h03);
    run(2'd2, 1'b0, 8'h00, 7'd0, 8'h03, "R9 setup", 100);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule